// File: doc/BRIEF.md
# PCI Initiator Termination Sequencer

This block owns the FRAME_L and IRDY_L lines of a PCI bus initiator from the moment a transaction is launched until the bus is handed back. It closes a transaction in one of two ways. In a normal ending, FRAME_L goes high as the final data phase begins, and IRDY_L goes high once the target completes that phase. In a master abort, no target claims the cycle within a fixed number of clocks, and the block releases FRAME_L and then IRDY_L in a fixed order.

Address and data driving, arbitration and parity belong to neighbouring logic. That logic pulses `start_i` to launch a cycle and raises `last_i` while the current data phase is the final one. `last_i` is only acted on while FRAME_L is driven low. All bus-side signals are active low and are sampled on the rising clock edge. `start_i` and `last_i` are active high internal strobes. The `done_o` and `mabort_o` flags each pulse for one clock and tell the owner how the transaction ended.

Top module: `pci_term_seq`

## Requirements
- R1: While reset is held and after it is released, `frame_n_o` and `irdy_n_o` are 1, `done_o` and `mabort_o` are 0, and the sequencer is idle.
- R2: A `start_i` sampled high while idle drives both `frame_n_o` and `irdy_n_o` to 0 in the following cycle.
- R3: While FRAME_L is low, a `last_i` sampled high raises `frame_n_o` in the next cycle, and `irdy_n_o` stays 0.
- R4: After FRAME_L is released, the first edge that samples `devsel_n_i`=0 together with `trdy_n_i`=0 or `stop_n_i`=0 raises `irdy_n_o` and pulses `done_o` in the next cycle.
- R5: Count the rising edges after FRAME_L first goes low (the first edge is the one that ends the first low cycle). If none of the first DEVSEL_WINDOW such edges (default 5) samples `devsel_n_i`=0, a master abort is detected on edge DEVSEL_WINDOW.
- R6: If FRAME_L is still low when the abort is detected, `frame_n_o` goes to 1 in the next cycle with `irdy_n_o` still 0. One cycle later `irdy_n_o` goes to 1 and `mabort_o` pulses.
- R7: If FRAME_L was already released when the abort is detected, `irdy_n_o` goes to 1 and `mabort_o` pulses in the next cycle.
- R8: Once any edge of a transaction samples `devsel_n_i`=0, no master abort occurs in that transaction, however long the target waits.
- R9: `irdy_n_o` is never 1 while `frame_n_o` is 0. `done_o` and `mabort_o` are never 1 together, and each lasts one cycle.
- R10: While FRAME_L is low, an edge that samples `stop_n_i`=0 with `devsel_n_i`=0 raises `frame_n_o` in the next cycle, as if the phase were the last.
- R11: A `start_i` sampled while a transaction is in progress has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, active high, honoured while idle |
| last_i | input | 1 | Current data phase is the final one, active high |
| devsel_n_i | input | 1 | Sampled DEVSEL_L from the target |
| trdy_n_i | input | 1 | Sampled TRDY_L from the target |
| stop_n_i | input | 1 | Sampled STOP_L from the target |
| frame_n_o | output | 1 | FRAME_L driven by the initiator |
| irdy_n_o | output | 1 | IRDY_L driven by the initiator |
| done_o | output | 1 | One-cycle pulse on normal completion |
| mabort_o | output | 1 | One-cycle pulse when the master abort sequence ends |

## Verification
Directed cases run the release sequence against separate patterns:
- A target that claims early and completes on the final phase.
- No target at all while FRAME_L is still low, which must give FRAME_L first and then IRDY_L.
- No target after a one-phase transaction has already dropped FRAME_L, which must give IRDY_L at once.
- DEVSEL_L arriving exactly on the last window edge, followed by a long wait.
- A STOP_L disconnect.
- A start request while busy.

Constrained random traffic then mixes late, early and absent DEVSEL_L with TRDY_L and STOP_L noise. This shows whether the window edge, the two abort orderings and the completion condition are told apart in every combination.

// File: rtl/pci_term_pkg.sv
package pci_term_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_FINAL = 2'd2,
        ST_ABORT = 2'd3
    } term_state_e;

    typedef struct packed {
        term_state_e state;
        logic        frame_n;
        logic        irdy_n;
        logic        done;
        logic        mabort;
    } seq_regs_t;

endpackage

// File: rtl/pci_term_window.sv
module pci_term_window #(
    parameter int WINDOW = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    input  logic live_i,
    input  logic devsel_n_i,
    output logic expire_o
);
    localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(WINDOW - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          seen;
    } win_regs_t;

    win_regs_t r_q, r_d;
    logic      seen_now;

    always_comb begin
        r_d      = r_q;
        seen_now = r_q.seen | ~devsel_n_i;
        expire_o = 1'b0;
        if (arm_i) begin
            r_d.cnt  = '0;
            r_d.seen = 1'b0;
        end else if (live_i) begin
            r_d.seen = seen_now;
            expire_o = ~seen_now && (r_q.cnt == LIMIT);
            if (!seen_now && (r_q.cnt != LIMIT)) begin
                r_d.cnt = r_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R8: a claimed transaction can never expire
    a_r8_quiet_after_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.seen && !arm_i) |-> !expire_o);

    // R5: the counter never passes the window limit
    a_r5_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.cnt <= LIMIT);

endmodule

// File: rtl/pci_term_fsm.sv
module pci_term_fsm
    import pci_term_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic last_i,
    input  logic devsel_n_i,
    input  logic trdy_n_i,
    input  logic stop_n_i,
    input  logic expire_i,
    output logic arm_o,
    output logic live_o,
    output logic frame_n_o,
    output logic irdy_n_o,
    output logic done_o,
    output logic mabort_o
);
    seq_regs_t r_q, r_d;
    logic      claim_end;
    logic      disconnect;

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.mabort = 1'b0;
        claim_end  = ~devsel_n_i & (~trdy_n_i | ~stop_n_i);
        disconnect = ~devsel_n_i & ~stop_n_i;
        arm_o      = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    arm_o       = 1'b1;
                    r_d.state   = ST_BURST;
                    r_d.frame_n = 1'b0;
                    r_d.irdy_n  = 1'b0;
                end
            end
            ST_BURST: begin
                if (expire_i) begin
                    r_d.state   = ST_ABORT;
                    r_d.frame_n = 1'b1;
                end else if (last_i || disconnect) begin
                    r_d.state   = ST_FINAL;
                    r_d.frame_n = 1'b1;
                end
            end
            ST_FINAL: begin
                if (expire_i) begin
                    r_d.state  = ST_IDLE;
                    r_d.irdy_n = 1'b1;
                    r_d.mabort = 1'b1;
                end else if (claim_end) begin
                    r_d.state  = ST_IDLE;
                    r_d.irdy_n = 1'b1;
                    r_d.done   = 1'b1;
                end
            end
            ST_ABORT: begin
                r_d.state  = ST_IDLE;
                r_d.irdy_n = 1'b1;
                r_d.mabort = 1'b1;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state   <= ST_IDLE;
            r_q.frame_n <= 1'b1;
            r_q.irdy_n  <= 1'b1;
            r_q.done    <= 1'b0;
            r_q.mabort  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign live_o    = (r_q.state == ST_BURST) || (r_q.state == ST_FINAL);
    assign frame_n_o = r_q.frame_n;
    assign irdy_n_o  = r_q.irdy_n;
    assign done_o    = r_q.done;
    assign mabort_o  = r_q.mabort;

    // R1: idle means both bus lines released
    a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_IDLE) |-> (frame_n_o && irdy_n_o));

    // R9: IRDY_L stays low while FRAME_L is low
    a_r9_irdy_under_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_n_o |-> !irdy_n_o);

    // R6: FRAME_L released with IRDY_L still asserted
    a_r6_irdy_on_frame_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(frame_n_o) |-> !irdy_n_o);

    // R6: abort step releases IRDY_L with the abort flag one cycle later
    a_r6_abort_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_ABORT) |=> (irdy_n_o && mabort_o));

    // R9: completion flags exclusive and single-cycle
    a_r9_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && mabort_o));
    a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R5: the window only expires during a live transaction
    a_r5_expire_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_i |-> live_o);

endmodule

// File: rtl/pci_term_seq.sv
module pci_term_seq #(
    parameter int DEVSEL_WINDOW = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic last_i,
    input  logic devsel_n_i,
    input  logic trdy_n_i,
    input  logic stop_n_i,
    output logic frame_n_o,
    output logic irdy_n_o,
    output logic done_o,
    output logic mabort_o
);
    logic arm;
    logic live;
    logic expire;

    pci_term_window #(
        .WINDOW(DEVSEL_WINDOW)
    ) window_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .arm_i     (arm),
        .live_i    (live),
        .devsel_n_i(devsel_n_i),
        .expire_o  (expire)
    );

    pci_term_fsm fsm_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .last_i    (last_i),
        .devsel_n_i(devsel_n_i),
        .trdy_n_i  (trdy_n_i),
        .stop_n_i  (stop_n_i),
        .expire_i  (expire),
        .arm_o     (arm),
        .live_o    (live),
        .frame_n_o (frame_n_o),
        .irdy_n_o  (irdy_n_o),
        .done_o    (done_o),
        .mabort_o  (mabort_o)
    );

    // R7: an abort from the final phase ends IRDY_L right away
    a_r7_abort_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire && frame_n_o) |=> (irdy_n_o && mabort_o));

    // R4: normal completion follows a claimed edge
    a_r4_done_claimed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(!devsel_n_i) && $past(frame_n_o)));

endmodule

// File: tb/pci_term_seq_tb_top.sv
module pci_term_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 5;
    localparam int MAX_CYCLES = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, last = 1'b0;
    logic devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
    logic frame_n, irdy_n, done, mabort;

    int n_vec = 0, n_bad = 0, cyc = 0;
    bit summary_done = 1'b0;

    // bench model
    int    m_st = 0, m_edges = 0;
    bit    m_seen = 0;
    logic  m_frame = 1, m_irdy = 1, m_done = 0, m_mab = 0;
    string m_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_term_seq #(.DEVSEL_WINDOW(WIN)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .last_i(last),
        .devsel_n_i(devsel_n), .trdy_n_i(trdy_n), .stop_n_i(stop_n),
        .frame_n_o(frame_n), .irdy_n_o(irdy_n), .done_o(done), .mabort_o(mabort)
    );

    function automatic bit claimed(logic dv, logic tr, logic sp);
        return !dv && (!tr || !sp);
    endfunction

    task automatic model_step();
        bit abort;
        m_done = 0;
        m_mab  = 0;
        if (m_st == 0) begin
            m_req = "R1";
            if (start) begin
                m_st = 1; m_frame = 0; m_irdy = 0; m_edges = 0; m_seen = 0;
                m_req = "R2";
            end
            return;
        end
        if (start) m_req = "R11";
        if (m_st == 3) begin
            m_st = 0; m_irdy = 1; m_mab = 1; m_req = "R6";
            return;
        end
        m_edges++;
        if (!devsel_n) m_seen = 1;
        abort = !m_seen && (m_edges == WIN);
        if (m_seen && m_edges >= WIN) m_req = "R8";
        if (m_st == 1) begin
            if (abort) begin
                m_st = 3; m_frame = 1; m_req = "R5";
            end else if (last) begin
                m_st = 2; m_frame = 1; m_req = "R3";
            end else if (!stop_n && !devsel_n) begin
                m_st = 2; m_frame = 1; m_req = "R10";
            end
        end else begin
            if (abort) begin
                m_st = 0; m_irdy = 1; m_mab = 1; m_req = "R7";
            end else if (claimed(devsel_n, trdy_n, stop_n)) begin
                m_st = 0; m_irdy = 1; m_done = 1; m_req = "R4";
            end
        end
    endtask

    task automatic compare();
        n_vec++;
        if ({frame_n, irdy_n, done, mabort} !== {m_frame, m_irdy, m_done, m_mab}) begin
            n_bad++;
            $display("FAIL %s cycle %0d: frame/irdy/done/mabort actual %b%b%b%b expected %b%b%b%b",
                     m_req, cyc, frame_n, irdy_n, done, mabort, m_frame, m_irdy, m_done, m_mab);
        end
        n_vec++;
        if ((!frame_n && irdy_n) || (done && mabort)) begin
            n_bad++;
            $display("FAIL R9 cycle %0d: actual frame %b irdy %b done %b mabort %b expected legal combination",
                     cyc, frame_n, irdy_n, done, mabort);
        end
    endtask

    // one cycle: check at falling edge, drive, let the model follow the rising edge
    task automatic cycle(input logic s, input logic l, input logic dv, input logic tr, input logic sp);
        @(negedge clk);
        compare();
        start = s; last = l; devsel_n = dv; trdy_n = tr; stop_n = sp;
        @(posedge clk);
        model_step();
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 1, 1, 1);
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > MAX_CYCLES) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, MAX_CYCLES);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_req = "R1";
        compare();                          // R1 during reset
        rst_n = 1'b1;
        idle_cycles(2);                     // R1 after reset

        // R2 R3 R4: early claim, two phases, completion by TRDY_L
        cycle(1, 0, 1, 1, 1);
        cycle(0, 0, 0, 0, 1);
        cycle(0, 1, 0, 0, 1);
        cycle(0, 0, 0, 0, 1);
        idle_cycles(2);

        // R5 R6: no target, FRAME_L still low
        cycle(1, 0, 1, 1, 1);
        idle_cycles(9);

        // R7: no target, single-phase transaction already released FRAME_L
        cycle(1, 0, 1, 1, 1);
        cycle(0, 1, 1, 1, 1);
        idle_cycles(8);

        // R8: DEVSEL_L on the last window edge, then a long wait
        cycle(1, 0, 1, 1, 1);
        for (int i = 0; i < WIN - 1; i++) cycle(0, 0, 1, 1, 1);
        cycle(0, 0, 0, 1, 1);
        for (int i = 0; i < 12; i++) cycle(0, 1, 1, 1, 1);
        cycle(0, 0, 0, 0, 1);
        idle_cycles(2);

        // R10 R11: disconnect by STOP_L and a start while busy
        cycle(1, 0, 1, 1, 1);
        cycle(1, 0, 0, 1, 1);
        cycle(0, 0, 0, 1, 0);
        cycle(1, 0, 0, 1, 0);
        idle_cycles(3);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            cycle(($urandom % 100) < 30, ($urandom % 100) < 35,
                  ($urandom % 100) >= 20, ($urandom % 100) >= 50,
                  ($urandom % 100) >= 10);
        end
        idle_cycles(8);
        finish_run();
    end
endmodule